// File: doc/BRIEF.md
# Sequential Address Link with Step Line

This block carries an address stream from a sender to a receiver over a set of address lines plus one extra step line. When a valid address is exactly the previous valid address plus a fixed stride, the sender raises the step line and leaves the address lines untouched. The receiver then rebuilds the address with its own adder. Any other valid address goes out in full with the step line low, and both ends take it as their new reference. For streams that are mostly sequential, such as instruction fetch, the address lines make no transitions for the in-sequence part.

Both halves sit in one top module so that the wire-level signals can be observed. The encoder registers its bus outputs one cycle after it samples the source. The decoder registers the rebuilt address one cycle after that. The stride is a parameter, for example 1 for word addressing or 4 for byte addresses of 32-bit words. Arithmetic wraps modulo 2^ADDR_W.

Top module: `seqbus_inc_link`

## Requirements
- R1: While reset is held, and after it, until the first valid input, bus_addr, bus_inc, bus_valid, dst_addr and dst_valid are all zero.
- R2: The first valid address after reset goes out in full with bus_inc low, even when it equals zero plus the stride.
- R3: A valid address equal to the last valid address plus STRIDE (modulo 2^ADDR_W) drives bus_inc high one cycle later, and bus_addr keeps its previous value.
- R4: A valid address that is not the successor goes out on bus_addr one cycle later with bus_inc low.
- R5: A cycle with src_valid low gives bus_valid low and bus_inc low one cycle later, and bus_addr unchanged.
- R6: Two cycles after a valid input, dst_addr equals that input address. Between valid transfers dst_addr holds its value.
- R7: dst_valid is bus_valid delayed by one cycle, so it is src_valid delayed by two cycles.
- R8: A successor that wraps past the all-ones address (for example 0xFFFFFFFC followed by 0x0 with stride 4) is treated as a step.
- R9: Idle cycles between two valid transfers do not break the sequence. The step test always compares against the last valid address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_addr | input | ADDR_W | Address to transfer |
| src_valid | input | 1 | src_addr is valid this cycle |
| bus_addr | output | ADDR_W | Encoded address lines |
| bus_inc | output | 1 | Step line: receiver adds STRIDE |
| bus_valid | output | 1 | Transfer present on the lines |
| dst_addr | output | ADDR_W | Rebuilt address at the receiver |
| dst_valid | output | 1 | dst_addr updated this cycle |

## Verification
The wire-level outputs (bus_addr, bus_inc, bus_valid) respond to the input sampled at one rising edge and are due after that edge. The rebuilt outputs (dst_addr, dst_valid) respond one edge later. The bench applies each input on a falling edge and samples on the following falling edge. At that sample it compares the bus outputs with the model result for the input just applied, and the receiver outputs with the model result for the input one step earlier. It also adds up bit transitions on the address lines, and checks that a run of in-sequence addresses adds none.

// File: rtl/seqbus_pkg.sv
// Shared definitions for the step-line address link.
// Assumes: consumers override the defaults through their own parameters.
package seqbus_pkg;

    localparam int DEF_ADDR_W = 32;
    localparam int DEF_STRIDE = 4;

    // How the encoder classifies one input cycle
    typedef enum logic [1:0] {
        K_IDLE = 2'd0,
        K_JUMP = 2'd1,
        K_STEP = 2'd2
    } xfer_kind_e;

endpackage

// File: rtl/seqbus_stride_inc.sv
// Adds the fixed stride to an address, modulo 2^ADDR_W.
// Assumes: STRIDE is non-negative. A zero stride reduces the adder to a wire.
module seqbus_stride_inc #(
    parameter int ADDR_W = seqbus_pkg::DEF_ADDR_W,
    parameter int STRIDE = seqbus_pkg::DEF_STRIDE
) (
    input  logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] next_addr
);

    generate
        if (STRIDE == 0) begin : g_wire
            // Zero stride: the successor is the address itself
            assign next_addr = base_addr;
        end else begin : g_add
            localparam logic [ADDR_W-1:0] STRIDE_V = ADDR_W'(STRIDE);
            // Modular add of the stride
            assign next_addr = base_addr + STRIDE_V;
        end
    endgenerate

endmodule

// File: rtl/seqbus_tx_enc.sv
// Sender half: compares each valid address with the last valid one plus the stride.
// On a match it raises the step line and freezes the address lines.
// Otherwise it drives the full address.
// Assumes: the synchronous reset clears the reference to zero. The armed flag
// forces the first transfer after reset to go out in full.
module seqbus_tx_enc #(
    parameter int ADDR_W = seqbus_pkg::DEF_ADDR_W,
    parameter int STRIDE = seqbus_pkg::DEF_STRIDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic              src_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_inc,
    output logic              bus_valid
);
    import seqbus_pkg::*;

    logic [ADDR_W-1:0] ref_q;
    logic              armed_q;
    logic [ADDR_W-1:0] succ_addr;
    logic [ADDR_W-1:0] bus_addr_q;
    logic              bus_inc_q;
    logic              bus_valid_q;
    xfer_kind_e        kind;

    seqbus_stride_inc #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_succ (
        .base_addr (ref_q),
        .next_addr (succ_addr)
    );

    // Classify the current input cycle
    always_comb begin
        if (!src_valid)
            kind = K_IDLE;
        else if (armed_q && (src_addr == succ_addr))
            kind = K_STEP;
        else
            kind = K_JUMP;
    end

    // Update the wire-level registers and the reference address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q       <= '0;
            armed_q     <= 1'b0;
            bus_addr_q  <= '0;
            bus_inc_q   <= 1'b0;
            bus_valid_q <= 1'b0;
        end else begin
            unique case (kind)
                K_STEP: begin
                    bus_inc_q   <= 1'b1;
                    bus_valid_q <= 1'b1;
                    ref_q       <= src_addr;
                end
                K_JUMP: begin
                    bus_addr_q  <= src_addr;
                    bus_inc_q   <= 1'b0;
                    bus_valid_q <= 1'b1;
                    ref_q       <= src_addr;
                    armed_q     <= 1'b1;
                end
                default: begin
                    bus_inc_q   <= 1'b0;
                    bus_valid_q <= 1'b0;
                end
            endcase
        end
    end

    assign bus_addr  = bus_addr_q;
    assign bus_inc   = bus_inc_q;
    assign bus_valid = bus_valid_q;

    AST_FIRST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && !armed_q) |=> (!bus_inc && bus_addr == $past(src_addr))); // R2
    AST_STEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_inc |-> (bus_valid && $stable(bus_addr))); // R3
    AST_JUMP_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_addr != succ_addr) |=> (!bus_inc && bus_addr == $past(src_addr))); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (!bus_inc && $stable(bus_addr))); // R5

endmodule

// File: rtl/seqbus_rx_dec.sv
// Receiver half: rebuilds the address from the lines. A step adds the stride
// to the held address. A full transfer copies the lines.
// Assumes: the reference starts at zero on reset, matching the sender.
module seqbus_rx_dec #(
    parameter int ADDR_W = seqbus_pkg::DEF_ADDR_W,
    parameter int STRIDE = seqbus_pkg::DEF_STRIDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_inc,
    input  logic              bus_valid,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              dst_valid
);

    localparam logic [ADDR_W-1:0] STRIDE_CHK = ADDR_W'(STRIDE);

    logic [ADDR_W-1:0] dst_q;
    logic              vld_q;
    logic [ADDR_W-1:0] step_addr;

    seqbus_stride_inc #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_step (
        .base_addr (dst_q),
        .next_addr (step_addr)
    );

    // Hold or rebuild the address and delay the valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= bus_valid;
            if (bus_valid)
                dst_q <= bus_inc ? step_addr : bus_addr;
        end
    end

    assign dst_addr  = dst_q;
    assign dst_valid = vld_q;

    AST_STEP_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_inc) |=> (dst_addr == $past(dst_addr) + STRIDE_CHK)); // R6
    AST_JUMP_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_inc) |=> (dst_addr == $past(bus_addr))); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> $stable(dst_addr)); // R6
    AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> dst_valid); // R7
    AST_IDLE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !dst_valid); // R7

endmodule

// File: rtl/seqbus_inc_link.sv
// Top: sender and receiver joined by the address lines and the step line.
// The wire-level signals are brought out so that transitions can be counted.
// Assumes: one clock domain and a zero-delay wire between the halves.
module seqbus_inc_link #(
    parameter int ADDR_W = seqbus_pkg::DEF_ADDR_W,
    parameter int STRIDE = seqbus_pkg::DEF_STRIDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic              src_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_inc,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              dst_valid
);

    seqbus_tx_enc #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_addr  (src_addr),
        .src_valid (src_valid),
        .bus_addr  (bus_addr),
        .bus_inc   (bus_inc),
        .bus_valid (bus_valid)
    );

    seqbus_rx_dec #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_inc   (bus_inc),
        .bus_valid (bus_valid),
        .dst_addr  (dst_addr),
        .dst_valid (dst_valid)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!bus_inc && !bus_valid && !dst_valid && bus_addr == '0 && dst_addr == '0)); // R1

endmodule

// File: tb/test_seqbus_inc_link.sv
// Bench for the step-line address link: directed corners plus a seeded random mix.
module test_seqbus_inc_link;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int STRIDE     = 4;
    localparam logic [ADDR_W-1:0] STRIDE_V = ADDR_W'(STRIDE);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] src_addr = '0;
    logic              src_valid = 1'b0;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_inc;
    logic              bus_valid;
    logic [ADDR_W-1:0] dst_addr;
    logic              dst_valid;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    longint trans = 0;

    // Model state
    logic [ADDR_W-1:0] m_ref = '0;
    logic              m_armed = 1'b0;
    logic [ADDR_W-1:0] m_bus = '0;
    logic [ADDR_W-1:0] m_dst = '0;
    logic              m_pv = 1'b0;
    logic [ADDR_W-1:0] last_bus = '0;

    seqbus_inc_link #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) i_seqbus_inc_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_addr  (src_addr),
        .src_valid (src_valid),
        .bus_addr  (bus_addr),
        .bus_inc   (bus_inc),
        .bus_valid (bus_valid),
        .dst_addr  (dst_addr),
        .dst_valid (dst_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            finish_run();
        end
    end

    task automatic chk(input string tag, input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Successor test used by the model
    function automatic logic is_step(input logic armed, input logic [ADDR_W-1:0] r, input logic [ADDR_W-1:0] a);
        return armed && (a == r + STRIDE_V);
    endfunction

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        src_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", bus_addr, '0);
        chk("R1", ADDR_W'(bus_inc), '0);
        chk("R1", ADDR_W'(bus_valid), '0);
        chk("R1", dst_addr, '0);
        chk("R1", ADDR_W'(dst_valid), '0);
        m_ref = '0; m_armed = 1'b0; m_bus = '0; m_dst = '0; m_pv = 1'b0;
        last_bus = bus_addr;
        rst_n = 1'b1;
    endtask

    // Apply one input cycle on a falling edge; check one falling edge later
    task automatic drive(input logic v, input logic [ADDR_W-1:0] a, input string tag);
        logic e_inc;
        src_valid = v;
        src_addr  = a;
        @(posedge clk);
        @(negedge clk);
        e_inc = 1'b0;
        if (v) begin
            if (is_step(m_armed, m_ref, a)) e_inc = 1'b1;
            else m_bus = a;
            m_ref = a;
            m_armed = 1'b1;
        end
        chk(tag, ADDR_W'(bus_inc), ADDR_W'(e_inc));
        chk(tag, bus_addr, m_bus);
        chk(tag, ADDR_W'(bus_valid), ADDR_W'(v));
        chk("R7", ADDR_W'(dst_valid), ADDR_W'(m_pv));
        chk("R6", dst_addr, m_dst);
        if (v) m_dst = a;
        m_pv = v;
        trans = trans + $countones(bus_addr ^ last_bus);
        last_bus = bus_addr;
    endtask

    initial begin
        longint seg_start;
        logic [ADDR_W-1:0] cur;
        int unsigned sel;
        void'($urandom(32'd1234));

        apply_reset();

        // R2: first transfer equals 0+stride but still goes out in full
        drive(1'b1, STRIDE_V, "R2");
        drive(1'b0, '0, "R5");
        drive(1'b1, 32'h0000_1000, "R4");

        // R3: sequential burst makes no line transitions
        seg_start = trans;
        cur = 32'h0000_1000;
        for (int i = 0; i < 20; i++) begin
            cur = cur + STRIDE_V;
            drive(1'b1, cur, "R3");
        end
        chk("R3", ADDR_W'(trans - seg_start), '0);

        // R4: repeated address and backward jump
        drive(1'b1, cur, "R4");
        drive(1'b1, cur - STRIDE_V, "R4");

        // R9: idle gap inside a sequence
        drive(1'b1, 32'h0000_0100, "R4");
        for (int i = 0; i < 3; i++) drive(1'b0, 32'hDEAD_BEEF, "R5");
        drive(1'b1, 32'h0000_0104, "R9");

        // R8: wrap past all ones
        drive(1'b1, 32'hFFFF_FFFC, "R4");
        drive(1'b1, 32'h0000_0000, "R8");
        drive(1'b1, 32'h0000_0004, "R8");

        // Reset mid-stream, then R2 again
        apply_reset();
        drive(1'b1, STRIDE_V, "R2");
        drive(1'b1, STRIDE_V + STRIDE_V, "R3");

        // Seeded random mix of steps, jumps and idles
        for (int i = 0; i < 400; i++) begin
            sel = $urandom_range(0, 99);
            if (sel < 60) drive(1'b1, m_ref + STRIDE_V, "R3");
            else if (sel < 85) drive(1'b1, $urandom, "R4");
            else drive(1'b0, $urandom, "R5");
        end
        drive(1'b0, '0, "R5");
        drive(1'b0, '0, "R5");

        $display("address-line transitions counted: %0d", trans);
        finish_run();
    end

endmodule